// File: doc/BRIEF.md
# Dual-Direction DMA Ring Doorbell Controller

This block holds the real-time state of a bank of DMA rings. Each ring has two sides. On the forward side software produces and the DMA engine consumes. On the reverse side the DMA engine produces completions and software consumes them. Both sides of a ring share one element count, but each side has its own occupancy counter, its own hardware index and its own registers. The element memory and the descriptors are kept elsewhere. This block tracks only the counts and positions that software and the DMA engine need to agree on.

Software reaches the state through a simple register bus. A read returns data one cycle after the request. A doorbell write adds a signed count to the occupancy of one side. The DMA engine drives three one-cycle strobes per ring: a forward consume, a reverse produce and a teardown-done. It reads back the forward-side consume position and the reverse-side produce position. A small two-state machine per ring holds the teardown handshake. Its states are TD_RUN and TD_DONE. The transition TD_RUN to TD_DONE (named *finish*) happens on the teardown-done strobe. The transition TD_DONE to TD_RUN (named *acknowledge*) happens on a reverse-side acknowledge write with no strobe in the same cycle. Every other case holds the state.

Top module: `dbr_ctrl`

## Requirements
- R1: Ring r occupies the byte window starting at r*0x2000. Its forward side sits at +0x0000 and its reverse side at +0x1000. Within a side, the offsets are: 0x0 occupancy (read), 0x4 doorbell (write, reads zero), 0x8 index (read) and 0xC size. `bus_rdata` is loaded one cycle after `bus_re` and holds its value between reads.
- R2: An occupancy read returns the count in bits 20:0 and a sticky error flag in bit 30. Bit 31 carries the teardown-complete flag on the reverse side and reads 0 on the forward side.
- R3: A doorbell write with bit 31 clear adds the two's-complement value in bits 7:0 to that side's occupancy at the next clock edge, so 0xFF removes one element.
- R4: A reverse-side doorbell write with bit 31 set is an acknowledge. It clears the teardown-complete flag and leaves the occupancy and both reverse indices unchanged, whatever bits 7:0 hold.
- R5: The ring's element count is a 16-bit field at offset 0xC. It is written only through the forward side. Both sides read the same value, and a write at the reverse side is ignored.
- R6: The reverse software read index (reverse offset 0x8) advances by the number of popped elements modulo the size. The reverse DMA produce index (`dma_rev_tail`) advances by one per produce strobe modulo the size.
- R7: The forward write index advances by the pushed count modulo the size. The forward index register and `dma_fwd_head` report the write index minus the occupancy, with the size added when the difference would be negative.
- R8: A forward consume strobe removes one element from the forward occupancy. A reverse produce strobe adds one element to the reverse occupancy.
- R9: Occupancy is clamped to the range 0 to size. A result outside that range sets the side's sticky error flag (bit 30), which stays set until reset.
- R10: When a doorbell and a DMA strobe reach the same side in one cycle, the occupancy changes by their sum, and the clamp and error test apply to that sum.
- R11: A teardown-done strobe sets the reverse teardown flag, which then holds even at zero occupancy until it is acknowledged. A strobe and an acknowledge in the same cycle leave the flag set.
- R12: Reset clears every occupancy, index, size, error flag, teardown flag and `bus_rdata`.
- R13: A read of an unmapped address returns zero, and a write to one changes nothing. Unmapped addresses are a ring number of NUM_RINGS or above, or any offset other than the four listed in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| dma_fwd_take | input | NUM_RINGS | Forward consume strobe per ring |
| dma_rev_give | input | NUM_RINGS | Reverse produce strobe per ring |
| dma_td_done | input | NUM_RINGS | Teardown-done strobe per ring |
| dma_fwd_head | output | NUM_RINGS*16 | Forward consume position per ring |
| dma_rev_tail | output | NUM_RINGS*16 | Reverse produce position per ring |

## Verification
Two pairs of functions can land in the same cycle. A doorbell write can meet a DMA strobe on the same side, and a teardown-done strobe can meet its acknowledge. The bench provokes the first pair by asserting the strobe in the same cycle as the doorbell write. It sets up a reverse side with zero occupancy and issues a pop alongside a produce, so a design that handles the two one after the other would report an underflow error. The sum is judged correct when the occupancy reads back as zero with a clear error bit. For the second pair, the bench pulses teardown-done together with an acknowledge and expects bit 31 to read back as set.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int DATA_W    = 32;
    localparam int OCC_W     = 21;
    localparam int DB_W      = 8;
    localparam int RING_LSB  = 13;
    localparam int SIDE_BIT  = 12;
    localparam int ERR_BIT   = 30;
    localparam int TD_BIT    = 31;

    typedef enum logic [1:0] {
        REG_OCC  = 2'd0,
        REG_DB   = 2'd1,
        REG_IDX  = 2'd2,
        REG_SIZE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        TD_RUN  = 1'b0,
        TD_DONE = 1'b1
    } td_state_e;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int ADDR_W    = 16
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic                       hit,
    output logic [ADDR_W-RING_LSB-1:0] ring,
    output logic                       rev,
    output reg_sel_e                   sel
);
    localparam int RING_W = ADDR_W - RING_LSB;

    logic in_range;

    always_comb begin
        ring     = addr[ADDR_W-1:RING_LSB];
        rev      = addr[SIDE_BIT];
        sel      = reg_sel_e'(addr[3:2]);
        in_range = ({1'b0, ring} < (RING_W+1)'(NUM_RINGS));
        hit      = in_range && (addr[SIDE_BIT-1:4] == '0) && (addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/dbr_side.sv
module dbr_side
    import dbr_pkg::*;
#(
    parameter bit FORWARD = 1'b1,
    parameter int SIZE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] size,
    input  logic              db_we,
    input  logic [DB_W-1:0]   db_val,
    input  logic              hw_stb,
    output logic [OCC_W-1:0]  occ,
    output logic              err,
    output logic [SIZE_W-1:0] sw_idx,
    output logic [SIZE_W-1:0] dma_idx
);
    localparam int SUM_W = OCC_W + 2;
    localparam int CNT_W = DB_W + 1;

    function automatic logic [SIZE_W-1:0] wrap_add(
        input logic [SIZE_W-1:0] base,
        input logic [CNT_W-1:0]  inc,
        input logic [SIZE_W-1:0] lim
    );
        logic [SIZE_W+CNT_W-1:0] sum;
        logic [SIZE_W+CNT_W-1:0] res;
        sum = {{CNT_W{1'b0}}, base} + {{SIZE_W{1'b0}}, inc};
        if (lim == '0) begin
            res = '0;
        end else begin
            res = sum % {{CNT_W{1'b0}}, lim};
        end
        return res[SIZE_W-1:0];
    endfunction

    logic signed [SUM_W-1:0] db_s, hw_s, sum_s, size_s;
    logic [OCC_W-1:0]        occ_q, occ_d;
    logic                    err_q;
    logic                    under, over;

    always_comb begin
        db_s   = db_we ? {{(SUM_W-DB_W){db_val[DB_W-1]}}, db_val} : '0;
        hw_s   = '0;
        if (hw_stb) begin
            hw_s = FORWARD ? '1 : SUM_W'(1);
        end
        size_s = {{(SUM_W-SIZE_W){1'b0}}, size};
        sum_s  = $signed({2'b00, occ_q}) + db_s + hw_s;
        under  = (sum_s < 0);
        over   = (sum_s > size_s);
        if (under) begin
            occ_d = '0;
        end else if (over) begin
            occ_d = {{(OCC_W-SIZE_W){1'b0}}, size};
        end else begin
            occ_d = sum_s[OCC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            err_q <= 1'b0;
        end else begin
            occ_q <= occ_d;
            if (under || over) begin
                err_q <= 1'b1;
            end
        end
    end

    assign occ = occ_q;
    assign err = err_q;

    generate
        if (FORWARD) begin : g_fwd
            logic [SIZE_W-1:0] wr_q;
            logic [CNT_W-1:0]  push;
            logic [OCC_W-1:0]  wr_ext, size_ext, head_ext;

            always_comb begin
                push     = (db_we && !db_val[DB_W-1]) ? {1'b0, db_val} : '0;
                wr_ext   = {{(OCC_W-SIZE_W){1'b0}}, wr_q};
                size_ext = {{(OCC_W-SIZE_W){1'b0}}, size};
                if (wr_ext >= occ_q) begin
                    head_ext = wr_ext - occ_q;
                end else begin
                    head_ext = size_ext - (occ_q - wr_ext);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wr_q <= '0;
                end else begin
                    wr_q <= wrap_add(wr_q, push, size);
                end
            end

            assign sw_idx  = head_ext[SIZE_W-1:0];
            assign dma_idx = head_ext[SIZE_W-1:0];
        end else begin : g_rev
            logic [SIZE_W-1:0] rd_q, wr_q;
            logic [CNT_W-1:0]  pop, give;

            always_comb begin
                pop  = (db_we && db_val[DB_W-1]) ? (-{1'b1, db_val}) : '0;
                give = {{(CNT_W-1){1'b0}}, hw_stb};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rd_q <= '0;
                    wr_q <= '0;
                end else begin
                    rd_q <= wrap_add(rd_q, pop, size);
                    wr_q <= wrap_add(wr_q, give, size);
                end
            end

            assign sw_idx  = rd_q;
            assign dma_idx = wr_q;
        end
    endgenerate
endmodule

// File: rtl/dbr_teardown.sv
module dbr_teardown
    import dbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_stb,
    input  logic ack_stb,
    output logic flag
);
    td_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TD_RUN: begin
                if (done_stb) begin
                    state_d = TD_DONE;
                end
            end
            TD_DONE: begin
                if (ack_stb && !done_stb) begin
                    state_d = TD_RUN;
                end
            end
            default: state_d = TD_RUN;
        endcase
    end

    always_comb begin
        flag = (state_q == TD_DONE);
    end
endmodule

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
    import dbr_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int ADDR_W    = 16,
    parameter int SIZE_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic                        bus_re,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_RINGS-1:0]        dma_fwd_take,
    input  logic [NUM_RINGS-1:0]        dma_rev_give,
    input  logic [NUM_RINGS-1:0]        dma_td_done,
    output logic [NUM_RINGS*SIZE_W-1:0] dma_fwd_head,
    output logic [NUM_RINGS*SIZE_W-1:0] dma_rev_tail
);
    localparam int RING_W = ADDR_W - RING_LSB;
    localparam int PAD_W  = DATA_W - SIZE_W;

    logic              dec_hit, dec_rev;
    logic [RING_W-1:0] dec_ring;
    reg_sel_e          dec_sel;

    logic [SIZE_W-1:0] size_q  [NUM_RINGS];
    logic [OCC_W-1:0]  occ_fwd [NUM_RINGS];
    logic [OCC_W-1:0]  occ_rev [NUM_RINGS];
    logic [SIZE_W-1:0] idx_fwd [NUM_RINGS];
    logic [SIZE_W-1:0] idx_rev [NUM_RINGS];
    logic [NUM_RINGS-1:0] err_fwd, err_rev, td_flag;
    logic [NUM_RINGS-1:0] db_fwd_we, db_rev_we, ack_we, size_we;
    logic [DATA_W-1:0] rd_mux;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-2:SIZE_W];

    dbr_decode #(.NUM_RINGS(NUM_RINGS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .ring (dec_ring),
        .rev  (dec_rev),
        .sel  (dec_sel)
    );

    generate
        for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
            logic wsel, db_sel;
            assign wsel         = bus_we && dec_hit && (dec_ring == RING_W'(r));
            assign db_sel       = wsel && (dec_sel == REG_DB);
            assign db_fwd_we[r] = db_sel && !dec_rev && !bus_wdata[TD_BIT];
            assign db_rev_we[r] = db_sel && dec_rev && !bus_wdata[TD_BIT];
            assign ack_we[r]    = db_sel && dec_rev && bus_wdata[TD_BIT];
            assign size_we[r]   = wsel && !dec_rev && (dec_sel == REG_SIZE);

            dbr_side #(.FORWARD(1'b1), .SIZE_W(SIZE_W)) u_fwd (
                .clk     (clk),
                .rst_n   (rst_n),
                .size    (size_q[r]),
                .db_we   (db_fwd_we[r]),
                .db_val  (bus_wdata[DB_W-1:0]),
                .hw_stb  (dma_fwd_take[r]),
                .occ     (occ_fwd[r]),
                .err     (err_fwd[r]),
                .sw_idx  (idx_fwd[r]),
                .dma_idx (dma_fwd_head[r*SIZE_W +: SIZE_W])
            );

            dbr_side #(.FORWARD(1'b0), .SIZE_W(SIZE_W)) u_rev (
                .clk     (clk),
                .rst_n   (rst_n),
                .size    (size_q[r]),
                .db_we   (db_rev_we[r]),
                .db_val  (bus_wdata[DB_W-1:0]),
                .hw_stb  (dma_rev_give[r]),
                .occ     (occ_rev[r]),
                .err     (err_rev[r]),
                .sw_idx  (idx_rev[r]),
                .dma_idx (dma_rev_tail[r*SIZE_W +: SIZE_W])
            );

            dbr_teardown u_td (
                .clk      (clk),
                .rst_n    (rst_n),
                .done_stb (dma_td_done[r]),
                .ack_stb  (ack_we[r]),
                .flag     (td_flag[r])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_RINGS; r++) begin
                size_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NUM_RINGS; r++) begin
                if (size_we[r]) begin
                    size_q[r] <= bus_wdata[SIZE_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (dec_hit && (dec_ring == RING_W'(r))) begin
                case (dec_sel)
                    REG_OCC: begin
                        if (dec_rev) begin
                            rd_mux = {td_flag[r], err_rev[r],
                                      {(DATA_W-OCC_W-2){1'b0}}, occ_rev[r]};
                        end else begin
                            rd_mux = {1'b0, err_fwd[r],
                                      {(DATA_W-OCC_W-2){1'b0}}, occ_fwd[r]};
                        end
                    end
                    REG_IDX:  rd_mux = {{PAD_W{1'b0}}, dec_rev ? idx_rev[r] : idx_fwd[r]};
                    REG_SIZE: rd_mux = {{PAD_W{1'b0}}, size_q[r]};
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/dbr_ctrl_chk.sv
module dbr_ctrl_chk
    import dbr_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int ADDR_W    = 16,
    parameter int SIZE_W    = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic                        bus_re,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        ack_bit,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_RINGS-1:0]        dma_rev_give,
    input logic [NUM_RINGS-1:0]        dma_td_done,
    input logic [NUM_RINGS*SIZE_W-1:0] dma_rev_tail,
    input logic [NUM_RINGS-1:0]        td_flag,
    input logic [OCC_W-1:0]            occ_fwd0,
    input logic [OCC_W-1:0]            occ_rev0,
    input logic [SIZE_W-1:0]           size0
);
    localparam int RING_W = ADDR_W - RING_LSB;

    logic              far_ring;
    logic              ack_ring0;
    logic [SIZE_W-1:0] tail0;

    assign far_ring  = ({1'b0, bus_addr[ADDR_W-1:RING_LSB]} >= (RING_W+1)'(NUM_RINGS));
    assign ack_ring0 = bus_we && ack_bit && (bus_addr == ADDR_W'(16'h1004));
    assign tail0     = dma_rev_tail[SIZE_W-1:0];

    p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && far_ring) |=> (bus_rdata == '0));

    p_td_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_td_done[0] |=> td_flag[0]);

    p_ack_keeps_occ_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ring0 && !dma_rev_give[0]) |=> $stable(occ_rev0));

    p_occ_within_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ_fwd0 != $past(occ_fwd0)) && (size0 == $past(size0))) |-> (occ_fwd0 <= size0));

    p_tail_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rev_give[0] && (size0 > SIZE_W'(1)) && ({1'b0, tail0} < {1'b0, size0} - 1'b1))
        |=> (tail0 == $past(tail0) + 1'b1));
endmodule

bind dbr_ctrl dbr_ctrl_chk #(
    .NUM_RINGS (NUM_RINGS),
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_addr     (bus_addr),
    .ack_bit      (bus_wdata[31]),
    .bus_rdata    (bus_rdata),
    .dma_rev_give (dma_rev_give),
    .dma_td_done  (dma_td_done),
    .dma_rev_tail (dma_rev_tail),
    .td_flag      (td_flag),
    .occ_fwd0     (occ_fwd[0]),
    .occ_rev0     (occ_rev[0]),
    .size0        (size_q[0])
);

// File: tb/sim_dbr_ctrl.sv
`timescale 1ns/1ps
module sim_dbr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  dma_fwd_take = '0;
    logic [3:0]  dma_rev_give = '0;
    logic [3:0]  dma_td_done = '0;
    logic [63:0] dma_fwd_head;
    logic [63:0] dma_rev_tail;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dbr_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .dma_fwd_take (dma_fwd_take),
        .dma_rev_give (dma_rev_give),
        .dma_td_done  (dma_td_done),
        .dma_fwd_head (dma_fwd_head),
        .dma_rev_tail (dma_rev_tail)
    );

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 16'h200C, 32'd8,         4'd5},  // R5 size of ring 1
        '{1'b1, 16'h200C, 32'd8,         4'd5},  // R5
        '{1'b1, 16'h300C, 32'd8,         4'd5},  // R5 shared with reverse
        '{1'b0, 16'h300C, 32'd5,         4'd5},  // R5 reverse write ignored
        '{1'b1, 16'h200C, 32'd8,         4'd5},  // R5
        '{1'b0, 16'h2004, 32'h03,        4'd3},  // R3 push 3
        '{1'b1, 16'h2000, 32'd3,         4'd3},  // R3
        '{1'b1, 16'h2008, 32'd0,         4'd7},  // R7 head = 3-3
        '{1'b0, 16'h2004, 32'hFF,        4'd3},  // R3 remove one
        '{1'b1, 16'h2000, 32'd2,         4'd3},  // R3
        '{1'b1, 16'h2008, 32'd1,         4'd7},  // R7 head = 3-2
        '{1'b0, 16'h2004, 32'h06,        4'd7},  // R7 push 6, write index wraps to 1
        '{1'b1, 16'h2000, 32'd8,         4'd3},  // R3
        '{1'b1, 16'h2008, 32'd1,         4'd7},  // R7 wrapped head = 8-(8-1)
        '{1'b0, 16'h2004, 32'h01,        4'd9},  // R9 overflow
        '{1'b1, 16'h2000, 32'h4000_0008, 4'd9},  // R9 clamped, error set
        '{1'b1, 16'h2004, 32'd0,         4'd1},  // R1 doorbell reads zero
        '{1'b1, 16'h8000, 32'd0,         4'd13}, // R13 ring 4 absent
        '{1'b1, 16'h2010, 32'd0,         4'd13}, // R13 unmapped offset
        '{1'b0, 16'h2010, 32'h55,        4'd13}, // R13 write ignored
        '{1'b1, 16'h2000, 32'h4000_0008, 4'd13}, // R13 state unchanged
        '{1'b1, 16'h3000, 32'd0,         4'd2}   // R2 reverse side idle
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] take, input logic [3:0] give, input logic [3:0] td);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        dma_fwd_take = take; dma_rev_give = give; dma_td_done = td;
        @(negedge clk);
        bus_we = 1'b0; dma_fwd_take = '0; dma_rev_give = '0; dma_td_done = '0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 4'b0, 4'b0, 4'b0);
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        check(bus_rdata, exp, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_rdata, 32'h0, "R12 rdata after reset");
        rst_n = 1'b1;
        rd_chk(16'h0000, 32'h0, "R12 fwd occ at reset");
        rd_chk(16'h1000, 32'h0, "R12 rev occ at reset");
        rd_chk(16'h000C, 32'h0, "R12 size at reset");
        check(dma_fwd_head[15:0], 32'h0, "R12 head at reset");

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                rd_chk(VEC[i].addr, VEC[i].data, $sformatf("R%0d vector %0d", VEC[i].req, i));
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R6 R8 reverse produce and software pop on ring 0
        wr(16'h000C, 32'd5);
        repeat (3) drive(1'b0, 16'h0, 32'h0, 4'b0, 4'b0001, 4'b0);
        rd_chk(16'h1000, 32'd3, "R8 reverse produce");
        check(dma_rev_tail[15:0], 32'd3, "R6 tail after three");
        wr(16'h1004, 32'hFE);
        rd_chk(16'h1000, 32'd1, "R3 reverse pop two");
        rd_chk(16'h1008, 32'd2, "R6 read index two");
        repeat (3) drive(1'b0, 16'h0, 32'h0, 4'b0, 4'b0001, 4'b0);
        check(dma_rev_tail[15:0], 32'd1, "R6 tail wraps");
        wr(16'h1004, 32'hFC);
        rd_chk(16'h1000, 32'd0, "R3 reverse pop four");
        rd_chk(16'h1008, 32'd1, "R6 read index wraps");

        // R7 R8 forward consume
        wr(16'h0004, 32'h02);
        drive(1'b0, 16'h0, 32'h0, 4'b0001, 4'b0, 4'b0);
        rd_chk(16'h0000, 32'd1, "R8 forward consume");
        check(dma_fwd_head[15:0], 32'd1, "R7 head port");

        // R10 doorbell and strobe in one cycle
        drive(1'b1, 16'h0004, 32'h03, 4'b0001, 4'b0, 4'b0);
        rd_chk(16'h0000, 32'd3, "R10 forward net sum");
        rd_chk(16'h0008, 32'd2, "R7 head after wrap");
        drive(1'b1, 16'h1004, 32'hFF, 4'b0, 4'b0001, 4'b0);
        rd_chk(16'h1000, 32'd0, "R10 reverse net zero no error");
        rd_chk(16'h1008, 32'd2, "R10 read index moved");

        // R9 underflow
        wr(16'h1004, 32'hFF);
        rd_chk(16'h1000, 32'h4000_0000, "R9 underflow error");

        // R11 R4 teardown handshake
        drive(1'b0, 16'h0, 32'h0, 4'b0, 4'b0, 4'b0001);
        rd_chk(16'h1000, 32'hC000_0000, "R11 flag set at zero occ");
        rd_chk(16'h0000, 32'd3, "R2 forward bit31 clear");
        wr(16'h1004, 32'h8000_00FF);
        rd_chk(16'h1000, 32'h4000_0000, "R4 ack clears flag only");
        rd_chk(16'h1008, 32'd3, "R4 ack leaves index");
        drive(1'b1, 16'h1004, 32'h8000_0000, 4'b0, 4'b0, 4'b0001);
        rd_chk(16'h1000, 32'hC000_0000, "R11 strobe beats ack");
        wr(16'h1004, 32'h8000_0000);
        rd_chk(16'h1000, 32'h4000_0000, "R11 later ack");

        // R12 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_rdata, 32'h0, "R12 rdata cleared");
        rst_n = 1'b1;
        rd_chk(16'h0000, 32'h0, "R12 fwd cleared");
        rd_chk(16'h1000, 32'h0, "R12 rev cleared");
        rd_chk(16'h2000, 32'h0, "R12 error cleared");
        rd_chk(16'h200C, 32'h0, "R12 size cleared");
        check(dma_rev_tail[15:0], 32'h0, "R12 tail cleared");

        finish_run();
    end
endmodule